// File: doc/BRIEF.md
# Clock Source Controller with Main-Clock Stop Fallback

This block holds the clock-source settings of a small microcontroller and turns them into enables for the analog parts around it. It runs from the low-speed internal oscillator. It drives an enable for that oscillator and an enable for the PLL, together with the PLL reference-divide and multiply selections. It also produces a clock-enable strobe that paces the CPU at 1/1, 1/2, 1/4 or 1/8 of its clock. Software sets everything through a byte-wide write port with three addresses. The analog oscillators, the PLL loop and the clock muxes are not part of this block.

Two hardware rules can override the software oscillator-off bit. The first applies while the internal oscillator is the selected CPU source. The second applies once a watchdog on the main clock decides that the main clock has stopped, provided both the stop-detect enable and the stop-interrupt enable are set. PLL settings are checked when they are written: a reserved code is refused. The divided reference frequency is also checked against a 2 to 5 MHz window for the main-clock frequency that is currently given. A sticky error flag records any violation.

Top module: `clk_source_ctrl`

## Requirements
- R1: After reset the PLL enable is 0, the oscillator enable is 1, the error flag and interrupt are 0, the divide field reads 00, the multiply factor reads 2, and the CPU strobe fires once every 8 clocks.
- R2: Control byte at address 0: bit0 = oscillator off (1 off, 0 on), bit1 = internal oscillator selected as CPU source, bit2 = stop-detect enable, bit3 = stop-interrupt enable, bits5:4 = CPU divide (00 /1, 01 /2, 10 /4, 11 /8). With bit1 = 0 and no fallback, oscillator enable is the inverse of bit0, one cycle after the write.
- R3: A control write with bit1 = 1 keeps the oscillator enabled whatever bit0 holds, and the off bit is stored as 0.
- R4: Address 2 sets the settle count L. Settle-done is low while the oscillator is disabled and rises L+1 cycles after the write that enables it.
- R5: PLL byte at address 1: bits1:0 = reference divide (00 /1, 01 /2, 10 /4), bits4:2 = multiply code, bit7 = PLL request. A divide code of 11 causes the whole write to be ignored and sets the error flag one cycle after the write.
- R6: Multiply codes 001, 010, 011 and 100 give the factors 2, 4, 6 and 8 on the factor output. The codes 000 and 101 to 111 cause the whole write to be ignored and set the error flag.
- R7: The PLL enable is high only while the request bit is set and 2 MHz ≤ (main frequency / divide) ≤ 5 MHz. When the rule fails with the request set, the error flag is set.
- R8: The stop detector counts main-clock rising edges in windows of 16 clocks. A window with no edge, while detection is enabled, marks the main clock stopped. If the interrupt is enabled, this raises a single one-cycle interrupt pulse on entry to the stopped state and no further pulses while it stays stopped.
- R9: While the main clock is stopped and both bit2 and bit3 are 1, the oscillator is forced on and the stored off bit is cleared, so the oscillator stays on after the main clock returns.
- R10: A new CPU divide takes effect only at a strobe. The period already under way finishes with the old divide.
- R11: The error flag is sticky until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 PLL, 2 settle count |
| wrData | input | 8 | Write data |
| mainFreqMhz | input | FREQ_W | Main-clock frequency in MHz |
| mainClkIn | input | 1 | Main clock, asynchronous to clk |
| oscEn | output | 1 | Low-speed internal oscillator enable |
| pllEn | output | 1 | PLL enable |
| pllDivSel | output | 2 | Active reference-divide code |
| pllMulFactor | output | 4 | Active PLL multiply factor |
| cfgErr | output | 1 | Sticky configuration error |
| settleDone | output | 1 | Oscillator settle time elapsed |
| stopIrq | output | 1 | One-cycle main-clock stop interrupt |
| cpuClkEn | output | 1 | CPU clock-enable strobe |

## Verification
Register state and the oscillator and PLL enables appear one cycle after the write clock edge. The PLL enable also responds in the same cycle to a change of the frequency input. The error flag from a range violation appears two cycles after the write. Settle-done rises L+1 cycles after an enabling write. The strobe holds its old divide for up to seven cycles after a write. Each expected value goes into the scoreboard tagged with the exact cycle in which it is due, and the monitor compares it in that cycle on the falling edge. The detector's window phase cannot be seen from outside, so the stop interrupt is searched for within a bounded span instead.

// File: rtl/clk_src_pkg.sv
`timescale 1ns/1ps
package clk_src_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PLL    = 2'd1;
  localparam logic [1:0] ADDR_SETTLE = 2'd2;

  // strobes and levels handed from control to datapath
  typedef struct packed {
    logic       oscRun;
    logic       detEn;
    logic       irqEn;
    logic [1:0] cpuDiv;
  } dpCtrl_t;

  function automatic logic divCodeOk(input logic [1:0] code);
    return code != 2'b11;
  endfunction

  function automatic logic mulCodeOk(input logic [2:0] code);
    return (code != 3'd0) && (code <= 3'd4);
  endfunction
endpackage

// File: rtl/clk_src_regs.sv
`timescale 1ns/1ps
module clk_src_regs
  import clk_src_pkg::*;
#(
  parameter int FREQ_W     = 5,
  parameter int SETTLE_W   = 8,
  parameter int SETTLE_RST = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [7:0]          wrData,
  input  logic [FREQ_W-1:0]   mainFreqMhz,
  input  logic                mainStopped,
  output dpCtrl_t             dpCtrl,
  output logic [SETTLE_W-1:0] settleLimit,
  output logic                oscEn,
  output logic                pllEn,
  output logic [1:0]          pllDivSel,
  output logic [3:0]          pllMulFactor,
  output logic                cfgErr
);
  localparam int CW = FREQ_W + 3;

  logic oscOffQ, srcIntQ, detEnQ, irqEnQ, pllReqQ, cfgErrQ;
  logic [1:0] cpuDivQ, refDivQ;
  logic [2:0] mulQ;
  logic [SETTLE_W-1:0] settleQ;
  logic fallback, inRange, pllWrOk;
  logic [CW-1:0] loLim, hiLim, freqExt;

  assign fallback = detEnQ && irqEnQ && mainStopped;
  assign pllWrOk  = divCodeOk(wrData[1:0]) && mulCodeOk(wrData[4:2]);

  // divided reference must sit in 2..5 MHz: 2*n <= f <= 5*n
  assign loLim   = CW'(2) << refDivQ;
  assign hiLim   = CW'(5) << refDivQ;
  assign freqExt = CW'(mainFreqMhz);
  assign inRange = (freqExt >= loLim) && (freqExt <= hiLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscOffQ <= 1'b0;
      srcIntQ <= 1'b1;
      detEnQ  <= 1'b0;
      irqEnQ  <= 1'b0;
      cpuDivQ <= 2'b11;
      refDivQ <= 2'b00;
      mulQ    <= 3'd1;
      pllReqQ <= 1'b0;
      settleQ <= SETTLE_W'(SETTLE_RST);
      cfgErrQ <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_CTRL) begin
        srcIntQ <= wrData[1];
        oscOffQ <= wrData[0] && !wrData[1] && !fallback;
        detEnQ  <= wrData[2];
        irqEnQ  <= wrData[3];
        cpuDivQ <= wrData[5:4];
      end else if (srcIntQ || fallback) begin
        oscOffQ <= 1'b0;
      end
      if (wrEn && wrAddr == ADDR_PLL && pllWrOk) begin
        refDivQ <= wrData[1:0];
        mulQ    <= wrData[4:2];
        pllReqQ <= wrData[7];
      end
      if (wrEn && wrAddr == ADDR_SETTLE) begin
        settleQ <= wrData[SETTLE_W-1:0];
      end
      if ((wrEn && wrAddr == ADDR_PLL && !pllWrOk) || (pllReqQ && !inRange)) begin
        cfgErrQ <= 1'b1;
      end
    end
  end

  assign oscEn        = !(oscOffQ && !srcIntQ && !fallback);
  assign pllEn        = pllReqQ && inRange;
  assign pllDivSel    = refDivQ;
  assign pllMulFactor = {mulQ, 1'b0};
  assign cfgErr       = cfgErrQ;
  assign settleLimit  = settleQ;

  always_comb begin
    dpCtrl.oscRun = oscEn;
    dpCtrl.detEn  = detEnQ;
    dpCtrl.irqEn  = irqEnQ;
    dpCtrl.cpuDiv = cpuDivQ;
  end
endmodule

// File: rtl/clk_src_dp.sv
`timescale 1ns/1ps
module clk_src_dp
  import clk_src_pkg::*;
#(
  parameter int WIN_CYC  = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mainClkIn,
  input  dpCtrl_t             dpCtrl,
  input  logic [SETTLE_W-1:0] settleLimit,
  output logic                mainStopped,
  output logic                stopIrq,
  output logic                settleDone,
  output logic                cpuClkEn
);
  localparam int WIN_W = $clog2(WIN_CYC);

  // stop detector
  logic [2:0] syncQ;
  logic [WIN_W-1:0] winQ;
  logic edgeQ, stoppedQ, irqQ, rise, winEnd, gotEdge;

  assign rise    = syncQ[1] && !syncQ[2];
  assign winEnd  = winQ == WIN_W'(WIN_CYC - 1);
  assign gotEdge = edgeQ || rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      winQ     <= '0;
      edgeQ    <= 1'b0;
      stoppedQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      syncQ <= {syncQ[1:0], mainClkIn};
      winQ  <= winEnd ? '0 : winQ + 1'b1;
      irqQ  <= 1'b0;
      if (winEnd) begin
        edgeQ <= 1'b0;
        if (dpCtrl.detEn && !gotEdge) begin
          if (!stoppedQ && dpCtrl.irqEn) irqQ <= 1'b1;
          stoppedQ <= 1'b1;
        end else begin
          stoppedQ <= 1'b0;
        end
      end else if (rise) begin
        edgeQ <= 1'b1;
      end
    end
  end

  assign mainStopped = stoppedQ;
  assign stopIrq     = irqQ;

  // oscillator settle counter
  logic [SETTLE_W-1:0] settleQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     settleQ <= '0;
    else if (!dpCtrl.oscRun)       settleQ <= '0;
    else if (settleQ < settleLimit) settleQ <= settleQ + 1'b1;
  end
  assign settleDone = dpCtrl.oscRun && (settleQ >= settleLimit);

  // CPU clock-enable prescaler, divide reloaded only at a strobe
  logic [2:0] divCntQ, divLim;
  logic [1:0] activeDivQ;
  assign divLim   = (3'd1 << activeDivQ) - 3'd1;
  assign cpuClkEn = divCntQ == divLim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCntQ    <= '0;
      activeDivQ <= 2'b11;
    end else if (cpuClkEn) begin
      divCntQ    <= '0;
      activeDivQ <= dpCtrl.cpuDiv;
    end else begin
      divCntQ <= divCntQ + 1'b1;
    end
  end
endmodule

// File: rtl/clk_source_ctrl.sv
`timescale 1ns/1ps
module clk_source_ctrl
  import clk_src_pkg::*;
#(
  parameter int FREQ_W     = 5,
  parameter int SETTLE_W   = 8,
  parameter int SETTLE_RST = 8,
  parameter int WIN_CYC    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic [FREQ_W-1:0] mainFreqMhz,
  input  logic              mainClkIn,
  output logic              oscEn,
  output logic              pllEn,
  output logic [1:0]        pllDivSel,
  output logic [3:0]        pllMulFactor,
  output logic              cfgErr,
  output logic              settleDone,
  output logic              stopIrq,
  output logic              cpuClkEn
);
  dpCtrl_t dpCtrl;
  logic [SETTLE_W-1:0] settleLimit;
  logic mainStopped;

  clk_src_regs #(.FREQ_W(FREQ_W), .SETTLE_W(SETTLE_W), .SETTLE_RST(SETTLE_RST)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .mainFreqMhz(mainFreqMhz), .mainStopped(mainStopped), .dpCtrl(dpCtrl),
    .settleLimit(settleLimit), .oscEn(oscEn), .pllEn(pllEn), .pllDivSel(pllDivSel),
    .pllMulFactor(pllMulFactor), .cfgErr(cfgErr)
  );

  clk_src_dp #(.WIN_CYC(WIN_CYC), .SETTLE_W(SETTLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .mainClkIn(mainClkIn), .dpCtrl(dpCtrl),
    .settleLimit(settleLimit), .mainStopped(mainStopped), .stopIrq(stopIrq),
    .settleDone(settleDone), .cpuClkEn(cpuClkEn)
  );
endmodule

// File: rtl/clk_source_ctrl_chk.sv
`timescale 1ns/1ps
module clk_source_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       oscEn,
  input logic       pllEn,
  input logic [1:0] pllDivSel,
  input logic [3:0] pllMulFactor,
  input logic       cfgErr,
  input logic       settleDone,
  input logic       stopIrq
);
  a_r4_settle_needs_osc: assert property (@(posedge clk) disable iff (!rstN)
    settleDone |-> oscEn);
  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    stopIrq |=> !stopIrq);
  a_r9_fallback_osc_on: assert property (@(posedge clk) disable iff (!rstN)
    stopIrq |-> oscEn);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
  a_r5_div_never_reserved: assert property (@(posedge clk) disable iff (!rstN)
    pllDivSel != 2'b11);
  a_r6_factor_legal: assert property (@(posedge clk) disable iff (!rstN)
    pllEn |-> (pllMulFactor[0] == 1'b0 && pllMulFactor != 4'd0 && pllMulFactor <= 4'd8));
endmodule

bind clk_source_ctrl clk_source_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .oscEn(oscEn), .pllEn(pllEn), .pllDivSel(pllDivSel),
  .pllMulFactor(pllMulFactor), .cfgErr(cfgErr), .settleDone(settleDone), .stopIrq(stopIrq)
);

// File: tb/sim_clk_source_ctrl.sv
`timescale 1ns/1ps
module sim_clk_source_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [4:0] mainFreqMhz = 5'd10;
  logic mainClkIn = 1'b0;
  logic oscEn, pllEn, cfgErr, settleDone, stopIrq, cpuClkEn;
  logic [1:0] pllDivSel;
  logic [3:0] pllMulFactor;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mainRun = 1'b1;
  bit finished = 1'b0;

  typedef struct { int due; int sig; int exp; string req; } item_t;
  item_t sbq[$];

  clk_source_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .mainFreqMhz(mainFreqMhz), .mainClkIn(mainClkIn), .oscEn(oscEn), .pllEn(pllEn),
    .pllDivSel(pllDivSel), .pllMulFactor(pllMulFactor), .cfgErr(cfgErr),
    .settleDone(settleDone), .stopIrq(stopIrq), .cpuClkEn(cpuClkEn)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  // signal ids: 0 oscEn 1 pllEn 2 cfgErr 3 settleDone 4 pllDivSel 5 pllMulFactor 6 stopIrq 7 cpuClkEn
  function automatic int sigVal(input int id);
    case (id)
      0: return int'(oscEn);
      1: return int'(pllEn);
      2: return int'(cfgErr);
      3: return int'(settleDone);
      4: return int'(pllDivSel);
      5: return int'(pllMulFactor);
      6: return int'(stopIrq);
      default: return int'(cpuClkEn);
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int due, input int sig, input int exp, input string req);
    item_t it;
    it.due = due; it.sig = sig; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: compares each expected item in its due cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      if (it.due == cyc) check(it.req, sigVal(it.sig), it.exp);
      else check({it.req, " (missed slot)"}, 0, 1);
    end
  end

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d, output int wc);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d; wc = cyc;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic measurePeriod(output int n);
    n = 0;
    @(negedge clk);
    while (!cpuClkEn) @(negedge clk);
    do begin @(negedge clk); n++; end while (!cpuClkEn && n < 64);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // main clock model: toggles every 3 cycles while running
  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1;
      if (mainRun) mainClkIn = ~mainClkIn;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int wc, per, s, irqCnt;
    bit found;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oscEn", oscEn, 1);
    check("R1 pllEn", pllEn, 0);
    check("R1 cfgErr", cfgErr, 0);
    check("R1 stopIrq", stopIrq, 0);
    check("R1 div field", pllDivSel, 0);
    check("R1 mul factor", pllMulFactor, 2);
    measurePeriod(per);
    check("R1 reset strobe period", per, 8);

    // R10 divide switch waits for strobe boundary
    @(negedge clk);
    while (!cpuClkEn) @(negedge clk);
    s = cyc;
    doWrite(2'd0, 8'h02, wc);
    for (int k = s + 2; k <= s + 7; k++) push(k, 7, 0, "R10 old divide holds");
    push(s + 8, 7, 1, "R10 strobe at old boundary");
    push(s + 9, 7, 1, "R10 new divide by 1");
    drain();
    doWrite(2'd0, 8'h12, wc);
    measurePeriod(per); measurePeriod(per);
    check("R10 divide by 2", per, 2);
    doWrite(2'd0, 8'h22, wc);
    measurePeriod(per); measurePeriod(per);
    check("R10 divide by 4", per, 4);

    // R2 off bit, R4 settle
    doWrite(2'd2, 8'h05, wc);
    doWrite(2'd0, 8'h01, wc);
    push(wc + 1, 0, 0, "R2 off bit disables oscillator");
    push(wc + 1, 3, 0, "R4 settle low while off");
    drain();
    doWrite(2'd0, 8'h00, wc);
    push(wc + 1, 0, 1, "R2 off bit 0 enables oscillator");
    push(wc + 5, 3, 0, "R4 settle not yet done");
    push(wc + 6, 3, 1, "R4 settle done after L+1");
    drain();

    // R3 source select overrides off bit
    doWrite(2'd0, 8'h01, wc);
    doWrite(2'd0, 8'h03, wc);
    push(wc + 1, 0, 1, "R3 off ignored when internal source");
    push(wc + 3, 0, 1, "R3 oscillator stays on");
    drain();

    // R5 R6 R7 PLL settings, freq 10 MHz
    doWrite(2'd1, 8'h89, wc);
    push(wc + 1, 1, 1, "R7 10/2 legal enables PLL");
    push(wc + 1, 4, 1, "R5 divide code 01");
    push(wc + 1, 5, 4, "R6 code 010 gives x4");
    push(wc + 2, 2, 0, "R7 no error for legal setting");
    drain();
    doWrite(2'd1, 8'h8D, wc);
    push(wc + 1, 5, 6, "R6 code 011 gives x6");
    drain();
    doWrite(2'd1, 8'h8B, wc);
    push(wc + 1, 2, 1, "R5 reserved divide sets error");
    push(wc + 1, 4, 1, "R5 reserved divide ignored");
    push(wc + 1, 5, 6, "R5 reserved write keeps multiply");
    drain();
    doWrite(2'd1, 8'h96, wc);
    push(wc + 1, 5, 6, "R6 reserved multiply ignored");
    push(wc + 1, 4, 1, "R6 reserved write keeps divide");
    drain();
    doWrite(2'd1, 8'h84, wc);
    push(wc + 1, 1, 0, "R7 10/1 out of range blocks PLL");
    push(wc + 1, 5, 2, "R6 code 001 gives x2");
    push(wc + 3, 2, 1, "R11 error stays set");
    drain();
    @(posedge clk); #1 mainFreqMhz = 5'd4; wc = cyc;
    push(wc, 1, 1, "R7 4/1 legal enables PLL");
    drain();
    @(posedge clk); #1 mainFreqMhz = 5'd12;
    doWrite(2'd1, 8'h92, wc);
    push(wc + 1, 1, 1, "R7 12/4 legal enables PLL");
    push(wc + 1, 5, 8, "R6 code 100 gives x8");
    push(wc + 1, 4, 2, "R5 divide code 10");
    drain();

    // R8 R9 stop detection and fallback
    doWrite(2'd0, 8'h0D, wc);
    push(wc + 1, 0, 0, "R2 off with main running");
    drain();
    irqCnt = 0;
    repeat (40) begin @(negedge clk); if (stopIrq) irqCnt++; end
    check("R8 no irq while main runs", irqCnt, 0);
    mainRun = 1'b0;
    found = 1'b0;
    for (int k = 0; k < 48 && !found; k++) begin
      @(negedge clk);
      if (stopIrq) begin
        found = 1'b1;
        check("R9 fallback forces oscillator on", oscEn, 1);
      end
    end
    check("R8 stop interrupt raised", found, 1);
    @(negedge clk);
    check("R8 interrupt is one cycle", stopIrq, 0);
    irqCnt = 0;
    repeat (40) begin @(negedge clk); if (stopIrq) irqCnt++; end
    check("R8 single pulse while stopped", irqCnt, 0);
    mainRun = 1'b1;
    repeat (48) @(negedge clk);
    check("R9 oscillator stays on after restart", oscEn, 1);
    doWrite(2'd0, 8'h0D, wc);
    push(wc + 1, 0, 0, "R2 off accepted after restart");
    drain();
    check("R11 error still set at end", cfgErr, 1);
    finishRun();
  end
endmodule